// File: doc/BRIEF.md
# Counting Binary/BCD Converter

This block converts between a plain binary value and packed binary-coded decimal by counting rather than by arithmetic. Two counters run side by side. The source counter is loaded with the value to convert and counts down. The destination counter starts from zero and counts up by the same number of steps. When the source reaches zero, the destination holds the same quantity in the other radix. An output register captures that result and a one-clock `done` strobe marks the update. The block then reloads itself from the present inputs and starts again, so it converts continuously without any start command.

With `mode` low, the binary input is loaded into a binary down-counter and a three-digit decimal up-counter produces the BCD result. With `mode` high, the roles of the two counters swap. The BCD input is loaded into the decimal counter, which counts down, and the binary counter counts up to the binary equivalent. A conversion of value N occupies N+2 clocks: N counting steps, one capture cycle and one reload cycle. Large values therefore take longer, and the update rate varies with the data.

Top module: `bcd_count_conv`

## Requirements
- R1: With `mode` low at the load edge, the `bcd_out` value presented with the next `done` is the decimal form of `bin_in` as sampled at that edge. Digit k occupies bits [4k+3:4k], with digit 0 the units.
- R2: With `mode` high at the load edge, the `bin_out` value presented with the next `done` equals 100·d2 + 10·d1 + d0. Here d2, d1 and d0 are the three BCD input digits, d0 at bits [3:0], each sampled at that edge.
- R3: In the high-`mode` direction, any input digit with a code above 9 is loaded as 9. For example, 12'hFAB converts to 999 and 12'h9A0 converts to 990.
- R4: Consecutive `done` pulses lie exactly N+2 clocks apart, where N is the value being converted. The load edge is the rising edge that ends the cycle in which `done` is high.
- R5: An input value of zero, in either direction, yields zero results and a `done` pulse every 2 clocks. The converter does not stall.
- R6: `done` is high for exactly one clock per conversion. Both outputs change only in the cycle where `done` is high and are held in every other cycle.
- R7: With each `done`, the output belonging to the exhausted source reads zero. This is `bin_out` when `mode` was low at the load and `bcd_out` when it was high.
- R8: While `rst_n` is low, both outputs are zero and `done` is low. The first rising edge after release loads the counters, so the first `done` arrives N+2 clocks after release.
- R9: Every 4-bit digit of `bcd_out` is at most 9 at all times.
- R10: `mode`, `bin_in` and `bcd_in` are sampled only at the load edge. Changes to them during a conversion do not alter that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0: binary to BCD, 1: BCD to binary; sampled at the load edge |
| bin_in | input | 8 | Binary value to convert when mode is 0 |
| bcd_in | input | 12 | Packed three-digit BCD value to convert when mode is 1 |
| bcd_out | output | 12 | Latched decimal counter at the end of the last conversion |
| bin_out | output | 10 | Latched binary counter at the end of the last conversion |
| done | output | 1 | One-clock strobe in the cycle the outputs update |

## Verification
A wrong carry or borrow between decimal digits shows up at the next `done` as a result that differs from the bench's computed value, or as a digit above 9. A miscounted step or a lost reload shows as a `done` spacing other than N+2, or as a missing `done` that the per-conversion cycle limit catches within a few thousand clocks. A register that latches at the wrong time shows as an output that moves between strobes, which is checked on every cycle of every conversion. Inputs are also scrambled in the middle of a conversion, so that sampling the inputs outside the load edge becomes visible in the very next result.

// File: rtl/bcdc_pkg.sv
// Package: shared digit type and helpers for the counting converter.
// Assumes a decimal digit is a 4-bit code holding 0..9.
package bcdc_pkg;

    typedef logic [3:0] digit_t;

    localparam digit_t DIGIT_MAX = 4'd9;

    // Saturate a loaded digit code so the decimal down-count stays defined.
    function automatic digit_t clamp_digit(input digit_t d);
        return (d > DIGIT_MAX) ? DIGIT_MAX : d;
    endfunction

endpackage

// File: rtl/bcdc_bin_counter.sv
// Module: loadable binary up/down counter.
// Does: loads a value, or steps by one in the chosen direction when
// enabled; reports when the count is zero.
// Assumes: load has priority over step; wrap-around is never reached in use.
module bcdc_bin_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] count,
    output logic         is_zero
);

    // Count register: reset, load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= up ? count + W'(1) : count - W'(1);
        end
    end

    // Zero detect feeding the terminal-count logic.
    always_comb begin
        is_zero = (count == '0);
    end

endmodule

// File: rtl/bcdc_dec_counter.sv
// Module: cascaded decimal up/down counter of DIGITS digits.
// Does: each digit wraps 9->0 counting up, or 0->9 counting down, and
// passes a ripple enable to the next higher digit. Loaded digits
// above 9 saturate to 9.
// Assumes: load has priority over step; digit 0 sits in bits [3:0].
module bcdc_dec_counter
    import bcdc_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [4*DIGITS-1:0] load_val,
    input  logic                step,
    input  logic                up,
    output logic [4*DIGITS-1:0] count,
    output logic                is_zero
);

    logic [DIGITS-1:0] ripple;

    assign ripple[0] = step;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        digit_t cur;
        digit_t nxt;

        // Next digit value for one step in the current direction.
        always_comb begin
            if (up) begin
                nxt = (cur == DIGIT_MAX) ? 4'd0 : cur + 4'd1;
            end else begin
                nxt = (cur == 4'd0) ? DIGIT_MAX : cur - 4'd1;
            end
        end

        // Digit register: reset, saturating load, or rippled step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur <= '0;
            end else if (load) begin
                cur <= clamp_digit(load_val[4*i +: 4]);
            end else if (ripple[i]) begin
                cur <= nxt;
            end
        end

        assign count[4*i +: 4] = cur;

        if (i < DIGITS - 1) begin : g_carry
            // Pass the step upward when this digit wraps.
            assign ripple[i+1] = ripple[i] &
                                 (up ? (cur == DIGIT_MAX) : (cur == 4'd0));
        end
    end

    // All-digits-zero detect for terminal count.
    always_comb begin
        is_zero = (count == '0);
    end

endmodule

// File: rtl/bcdc_sequencer.sv
// Module: reload sequencer for the counting converter.
// Does: turns the source zero-detect into an active-low terminal-count
// flag, registers it into the preset-enable flip-flop, gates counting,
// and raises capture and a registered done strobe.
// Assumes: preset-enable is asserted out of reset so the first edge loads.
module bcdc_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic src_zero,
    output logic preset_en,
    output logic step,
    output logic capture,
    output logic done
);

    logic term_n;

    // Active-low terminal count and the derived strobes.
    always_comb begin
        term_n  = ~src_zero;
        capture = ~term_n & ~preset_en;
        step    = term_n & ~preset_en;
    end

    // Preset-enable flip-flop: asserts one edge after terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset_en <= 1'b1;
        end else begin
            preset_en <= ~term_n & ~preset_en;
        end
    end

    // Done strobe: high in the cycle the output register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= capture;
        end
    end

endmodule

// File: rtl/bcd_count_conv.sv
// Module: continuous binary<->BCD converter built from lockstep counters.
// Does: on each preset-enable edge loads the source counter from the
// selected input and clears the destination; both step until the
// source is zero; the result is latched with a done strobe; repeats.
// Assumes: inputs are stable around the load edge; mode is sampled there.
module bcd_count_conv #(
    parameter int BIN_W  = 8,
    parameter int DIGITS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode,
    input  logic [BIN_W-1:0]            bin_in,
    input  logic [4*DIGITS-1:0]         bcd_in,
    output logic [4*DIGITS-1:0]         bcd_out,
    output logic [$clog2(10**DIGITS)-1:0] bin_out,
    output logic                        done
);

    localparam int BCD_W = 4 * DIGITS;
    localparam int CNT_W = $clog2(10**DIGITS);

    logic             mode_q;
    logic             preset_en;
    logic             step;
    logic             capture;
    logic             src_zero;
    logic [CNT_W-1:0] bin_cnt;
    logic [BCD_W-1:0] dec_cnt;
    logic             bin_zero;
    logic             dec_zero;
    logic [CNT_W-1:0] bin_load;
    logic [BCD_W-1:0] dec_load;

    // Direction register: sampled together with the counter load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (preset_en) begin
            mode_q <= mode;
        end
    end

    // Load values: the source takes the input, the destination clears.
    always_comb begin
        bin_load = mode ? '0 : CNT_W'(bin_in);
        dec_load = mode ? bcd_in : '0;
        src_zero = mode_q ? dec_zero : bin_zero;
    end

    bcdc_bin_counter #(
        .W (CNT_W)
    ) u_bin (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (preset_en),
        .load_val (bin_load),
        .step     (step),
        .up       (mode_q),
        .count    (bin_cnt),
        .is_zero  (bin_zero)
    );

    bcdc_dec_counter #(
        .DIGITS (DIGITS)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (preset_en),
        .load_val (dec_load),
        .step     (step),
        .up       (~mode_q),
        .count    (dec_cnt),
        .is_zero  (dec_zero)
    );

    bcdc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_zero  (src_zero),
        .preset_en (preset_en),
        .step      (step),
        .capture   (capture),
        .done      (done)
    );

    // Output register: holds both counters from the end of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_out <= '0;
            bin_out <= '0;
        end else if (capture) begin
            bcd_out <= dec_cnt;
            bin_out <= bin_cnt;
        end
    end

endmodule

// File: rtl/bcdc_checker.sv
// Module: property checker for bcd_count_conv, attached by bind.
// Observes ports only; all properties are disabled during reset.
module bcdc_checker #(
    parameter int DIGITS = 3,
    parameter int CNT_W  = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic [4*DIGITS-1:0] bcd_out,
    input logic [CNT_W-1:0]    bin_out
);

    function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    // R6: strobe lasts one clock
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: outputs move only with the strobe
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(bcd_out) && $stable(bin_out)));

    // R9: every decimal digit is a legal code
    a_r9_digits: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(bcd_out));

    // R7: the exhausted source side reads zero at each result
    a_r7_source_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bin_out == '0 || bcd_out == '0));

    // R2: binary result stays within the decimal range
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bin_out) < 10**DIGITS);

endmodule

bind bcd_count_conv bcdc_checker #(
    .DIGITS (DIGITS),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .bcd_out (bcd_out),
    .bin_out (bin_out)
);

// File: tb/tb_bcd_count_conv.sv
module tb_bcd_count_conv;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [7:0]  bin_in = '0;
    logic [11:0] bcd_in = '0;
    logic [11:0] bcd_out;
    logic [9:0]  bin_out;
    logic        done;

    int checks = 0;
    int errors = 0;

    bcd_count_conv dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .bin_in  (bin_in),
        .bcd_in  (bcd_in),
        .bcd_out (bcd_out),
        .bin_out (bin_out),
        .done    (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int bcd_value(input logic [11:0] b);
        int d [3];
        for (int i = 0; i < 3; i++) begin
            d[i] = int'(b[4*i +: 4]);
            if (d[i] > 9) d[i] = 9;
        end
        return d[2] * 100 + d[1] * 10 + d[0];
    endfunction

    function automatic logic digits_ok(input logic [11:0] b);
        return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd9) && (b[11:8] <= 4'd9);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for done, counting cycles; returns count (LIMIT on timeout).
    task automatic wait_done(input logic scramble, output int cyc, output logic held);
        logic [11:0] pb;
        logic [9:0]  pn;
        pb   = bcd_out;
        pn   = bin_out;
        cyc  = 0;
        held = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
            if (scramble && cyc == 2) begin
                mode   = ~mode;
                bin_in = 8'($urandom);
                bcd_in = 12'($urandom);
            end
            if (!done && (bcd_out != pb || bin_out != pn)) held = 1'b0;
        end while (!done && cyc < LIMIT);
    endtask

    // One conversion started at a negedge where done is high.
    task automatic convert(input logic m, input logic [7:0] b, input logic [11:0] d,
                           input logic scramble);
        int   n;
        int   cyc;
        logic held;
        logic [11:0] exp_bcd;
        logic [9:0]  exp_bin;
        mode   = m;
        bin_in = b;
        bcd_in = d;
        if (!m) begin
            n = int'(b);
            exp_bcd = to_bcd(n);
            exp_bin = '0;
        end else begin
            n = bcd_value(d);
            exp_bcd = '0;
            exp_bin = 10'(n);
        end
        wait_done(scramble, cyc, held);
        check(cyc < LIMIT, "R4 done timeout", cyc, n + 2);
        check(cyc == n + 2, "R4 period", cyc, n + 2);
        if (!m) begin
            check(bcd_out == exp_bcd, scramble ? "R10 R1 bcd result" : "R1 bcd result",
                  int'(bcd_out), int'(exp_bcd));
            check(bin_out == '0, "R7 bin_out zero", int'(bin_out), 0);
        end else begin
            check(bin_out == exp_bin, scramble ? "R10 R2 bin result" : "R2 bin result",
                  int'(bin_out), int'(exp_bin));
            check(bcd_out == '0, "R7 bcd_out zero", int'(bcd_out), 0);
        end
        check(digits_ok(bcd_out), "R9 digit codes", int'(bcd_out), int'(exp_bcd));
        check(held, "R6 outputs held between strobes", 0, 1);
        @(negedge clk);
        check(!done, "R6 done single cycle", int'(done), 0);
        // step back to a done-high point: wait for next strobe of the
        // conversion already loaded with these inputs
        wait_done(1'b0, cyc, held);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000 - 100) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int   cyc;
        logic held;
        int   v;
        void'($urandom(32'd12345));

        // R8: reset state
        mode   = 1'b0;
        bin_in = 8'd5;
        repeat (3) @(negedge clk);
        check(bcd_out == '0 && bin_out == '0, "R8 outputs zero in reset",
              int'(bcd_out) + int'(bin_out), 0);
        check(!done, "R8 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        wait_done(1'b0, cyc, held);
        check(cyc == 7, "R8 first done after release", cyc, 7);
        check(bcd_out == 12'h005, "R1 first result", int'(bcd_out), 5);

        // Directed corners
        convert(1'b0, 8'd0,   12'h000, 1'b0);  // R5 zero forward
        convert(1'b1, 8'd0,   12'h000, 1'b0);  // R5 zero reverse
        convert(1'b0, 8'd255, 12'h000, 1'b0);  // R1 maximum
        convert(1'b0, 8'd9,   12'h000, 1'b0);  // R1 digit wrap
        convert(1'b0, 8'd100, 12'h000, 1'b0);  // R1 double wrap
        convert(1'b1, 8'd0,   12'h999, 1'b0);  // R2 maximum
        convert(1'b1, 8'd0,   12'hFAB, 1'b0);  // R3 clamp to 999
        convert(1'b1, 8'd0,   12'h9A0, 1'b0);  // R3 clamp to 990
        convert(1'b1, 8'd0,   12'h010, 1'b0);  // R2 borrow
        convert(1'b0, 8'd37,  12'h000, 1'b1);  // R10 scramble forward
        convert(1'b1, 8'd0,   12'h456, 1'b1);  // R10 scramble reverse

        // Random mix
        for (int i = 0; i < 30; i++) begin
            v = int'($urandom % 4);
            if (v == 0) begin
                convert(1'b1, 8'($urandom), 12'($urandom), 1'b0);
            end else if (v == 1) begin
                convert(1'b1, 8'($urandom), to_bcd(int'($urandom % 1000)), i[0]);
            end else begin
                convert(1'b0, 8'($urandom), 12'($urandom), i[0]);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule